// File: doc/BRIEF.md
# Write-Path Store Buffer Router

This block sits between the processor's write port and a single-outstanding bus master. For each write it picks one of three paths. A write can be refused with an access error. It can be posted into a small FIFO that drains to the bus later. Or it can go straight to the bus as an immediate cycle, and the processor waits for that cycle to complete. The choice depends on a few things. Two attributes travel with the write: a cache-inhibit flag and a precise flag. A flag says whether the address matched a region register. A small control word sets two behaviours: it enables the buffer, and it write-protects writes that match no region.

The FIFO holds a full address, data and byte-enable set per entry. It drains oldest first, one entry per bus handshake. A write that goes straight to the bus must wait until every buffered write has reached the bus and the bus is idle, so the bus sees writes in program order. When the buffer is disabled while entries are still queued, those entries still drain. Writes that arrive afterwards follow them once the queue is empty.

Top module: `storeRouter`

## Requirements
- R1: After reset the control word `cfgOut` is 0: bit 0 is buffer enable, bit 1 is default write-protect, bit 2 is cache enable. `busReq` and `cpuErr` are low. A write that matches no region is not faulted.
- R2: A write with `cpuRegionHit`=0 while bit 1 is set is answered with `cpuReady`=1 and `cpuErr`=1 in the same cycle, and no bus cycle follows. A write with `cpuRegionHit`=1 is not faulted.
- R3: With bit 0 set, a write that is not both inhibited (`cpuInhibit`=1) and precise (`cpuPrecise`=1) is accepted into the buffer in the cycle it is presented, as long as the buffer is not full. It reaches the bus later.
- R4: A write with `cpuInhibit`=1 and `cpuPrecise`=1 always goes straight to the bus, whatever the value of bit 0. Its `cpuReady` rises only in the cycle its bus handshake completes.
- R5: With bit 0 clear, every non-faulted write goes straight to the bus and completes with its bus handshake.
- R6: A direct write issues no bus cycle until all earlier buffered writes have finished on the bus.
- R7: The buffer holds DEPTH (4) entries. While a buffered bus cycle is stalled, at most DEPTH further writes are accepted. The next bufferable write sees `cpuReady` held low until an entry frees.
- R8: The buffer drains oldest first, one entry per `busReq`&&`busReady` handshake. The bus address, data and byte enables hold steady while `busReq` waits for `busReady`.
- R9: Clearing bit 0 while entries remain discards none of them. A write that arrives afterwards reaches the bus after all of them.
- R10: `cpuErr` is never high without `cpuReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Write request, held until `cpuReady` |
| cpuAddr | input | AW | Write address |
| cpuData | input | DW | Write data |
| cpuBe | input | DW/8 | Byte enables |
| cpuInhibit | input | 1 | 1 = cache-inhibited, 0 = write-through |
| cpuPrecise | input | 1 | 1 = precise mode |
| cpuRegionHit | input | 1 | Write matched a region register |
| cpuReady | output | 1 | Write accepted or completed this cycle |
| cpuErr | output | 1 | Access error, valid with `cpuReady` |
| busReq | output | 1 | Bus write cycle pending |
| busAddr | output | AW | Bus address |
| busData | output | DW | Bus data |
| busBe | output | DW/8 | Bus byte enables |
| busReady | input | 1 | Bus accepts the pending cycle |
| ctlWe | input | 1 | Load the control word |
| ctlWdata | input | 3 | New control word |
| cfgOut | output | 3 | Current control word |

## Verification
The hardest state to reach is a bufferable write arriving while the buffer is full, or a direct write (or a write arriving just after the buffer is disabled) arriving while earlier entries are still queued. Either state needs the bus to be held off for a while. The bench drives `busReady` low, fills the queue with posted writes, and presents the competing write. A forked process then releases the bus a fixed number of cycles later. The bench measures how long `cpuReady` stays low, and its scoreboard checks the final bus order against program order.

// File: rtl/routerPkg.sv
package routerPkg;
  localparam int CFG_W     = 3;
  localparam int CFG_BUFEN = 0;
  localparam int CFG_WPROT = 1;
  localparam int CFG_CACHE = 2;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_BUF  = 2'd1,
    BUS_DIR  = 2'd2
  } busState_t;

  typedef struct packed {
    logic push;     // write cpu payload into the FIFO tail
    logic popLoad;  // move FIFO head onto the bus registers
    logic cpuLoad;  // move cpu payload onto the bus registers
  } dpStrobes_t;
endpackage

// File: rtl/routerDatapath.sv
module routerDatapath
  import routerPkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobes_t            stb,
  input  logic [AW-1:0]         cpuAddr,
  input  logic [DW-1:0]         cpuData,
  input  logic [DW/8-1:0]       cpuBe,
  output logic [AW-1:0]         busAddr,
  output logic [DW-1:0]         busData,
  output logic [DW/8-1:0]       busBe,
  output logic                  fifoFull,
  output logic                  fifoEmpty,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel
);
  localparam int BEW  = DW / 8;
  localparam int EW   = AW + DW + BEW;
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [EW-1:0]   entryMem [DEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr;
  logic [CNTW-1:0] count;
  logic [EW-1:0]   headEntry;

  function automatic logic [PTRW-1:0] nextPtr(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headEntry = entryMem[rdPtr];
  assign fifoFull  = (count == CNTW'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign fillLevel = count;

  always_ff @(posedge clk) begin
    if (stb.push) entryMem[wrPtr] <= {cpuAddr, cpuData, cpuBe};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push)    wrPtr <= nextPtr(wrPtr);
      if (stb.popLoad) rdPtr <= nextPtr(rdPtr);
      case ({stb.push, stb.popLoad})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr <= '0;
      busData <= '0;
      busBe   <= '0;
    end else if (stb.popLoad) begin
      {busAddr, busData, busBe} <= headEntry;
    end else if (stb.cpuLoad) begin
      busAddr <= cpuAddr;
      busData <= cpuData;
      busBe   <= cpuBe;
    end
  end
endmodule

// File: rtl/routerControl.sv
module routerControl
  import routerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuInhibit,
  input  logic             cpuPrecise,
  input  logic             cpuRegionHit,
  input  logic             ctlWe,
  input  logic [CFG_W-1:0] ctlWdata,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  input  logic             busReady,
  output logic             cpuReady,
  output logic             cpuErr,
  output logic             busReq,
  output logic [CFG_W-1:0] cfgOut,
  output dpStrobes_t       stb
);
  busState_t        state, stateNext;
  logic [CFG_W-1:0] cfg;
  logic             dirBusy, fault, bufferable, directGo, busDone;

  always_ff @(posedge clk) begin
    if (!rstN)      cfg <= '0;
    else if (ctlWe) cfg <= ctlWdata;
  end
  assign cfgOut = cfg;

  // A direct write in flight owns the cpu port until its handshake.
  assign dirBusy    = (state == BUS_DIR);
  assign fault      = cpuReq && !dirBusy && !cpuRegionHit && cfg[CFG_WPROT];
  assign bufferable = cfg[CFG_BUFEN] && !(cpuInhibit && cpuPrecise);
  assign directGo   = (state == BUS_IDLE) && fifoEmpty && cpuReq && !fault && !bufferable;
  assign busDone    = (state != BUS_IDLE) && busReady;

  always_comb begin
    stb.push    = cpuReq && !dirBusy && !fault && bufferable && !fifoFull;
    stb.popLoad = (state == BUS_IDLE) && !fifoEmpty;
    stb.cpuLoad = directGo;
  end

  assign cpuReady = fault || stb.push || (dirBusy && busReady);
  assign cpuErr   = fault;
  assign busReq   = (state != BUS_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      BUS_IDLE: begin
        if (stb.popLoad)  stateNext = BUS_BUF;
        else if (directGo) stateNext = BUS_DIR;
      end
      BUS_BUF, BUS_DIR: if (busDone) stateNext = BUS_IDLE;
      default: stateNext = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= BUS_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/storeRouter.sv
module storeRouter
  import routerPkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic [AW-1:0]    cpuAddr,
  input  logic [DW-1:0]    cpuData,
  input  logic [DW/8-1:0]  cpuBe,
  input  logic             cpuInhibit,
  input  logic             cpuPrecise,
  input  logic             cpuRegionHit,
  output logic             cpuReady,
  output logic             cpuErr,
  output logic             busReq,
  output logic [AW-1:0]    busAddr,
  output logic [DW-1:0]    busData,
  output logic [DW/8-1:0]  busBe,
  input  logic             busReady,
  input  logic             ctlWe,
  input  logic [CFG_W-1:0] ctlWdata,
  output logic [CFG_W-1:0] cfgOut
);
  localparam int CNTW = $clog2(DEPTH + 1);

  dpStrobes_t      stb;
  logic            fifoFull, fifoEmpty;
  logic [CNTW-1:0] fillLevel;

  routerControl uCtl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuInhibit(cpuInhibit), .cpuPrecise(cpuPrecise),
    .cpuRegionHit(cpuRegionHit), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .busReady(busReady),
    .cpuReady(cpuReady), .cpuErr(cpuErr), .busReq(busReq),
    .cfgOut(cfgOut), .stb(stb)
  );

  routerDatapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuBe(cpuBe),
    .busAddr(busAddr), .busData(busData), .busBe(busBe),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fillLevel(fillLevel)
  );
endmodule

// File: rtl/storeRouterChk.sv
module storeRouterChk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       cpuReq,
  input logic                       cpuInhibit,
  input logic                       cpuPrecise,
  input logic                       cpuRegionHit,
  input logic                       cpuReady,
  input logic                       cpuErr,
  input logic                       busReq,
  input logic [AW-1:0]              busAddr,
  input logic [DW-1:0]              busData,
  input logic [DW/8-1:0]            busBe,
  input logic                       busReady,
  input logic [2:0]                 cfgOut,
  input logic [$clog2(DEPTH+1)-1:0] fillLevel
);
  // R10
  err_with_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> cpuReady);

  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> (cpuReq && !cpuRegionHit && cfgOut[1]));

  // R4
  precise_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuReady && !cpuErr && cpuInhibit && cpuPrecise) |-> (busReq && busReady));

  // R5
  disabled_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuReady && !cpuErr && !cfgOut[0]) |-> (busReq && busReady));

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> (busReq && $stable(busAddr) && $stable(busData) && $stable(busBe)));

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind storeRouter storeRouterChk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuInhibit(cpuInhibit),
  .cpuPrecise(cpuPrecise), .cpuRegionHit(cpuRegionHit), .cpuReady(cpuReady),
  .cpuErr(cpuErr), .busReq(busReq), .busAddr(busAddr), .busData(busData),
  .busBe(busBe), .busReady(busReady), .cfgOut(cfgOut), .fillLevel(fillLevel)
);

// File: tb/sim_storeRouter.sv
`timescale 1ns/1ps
module sim_storeRouter;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BEW = DW / 8;
  localparam int EW = AW + DW + BEW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuData = '0;
  logic [BEW-1:0] cpuBe = '0;
  logic cpuInhibit = 1'b0, cpuPrecise = 1'b0, cpuRegionHit = 1'b0;
  logic cpuReady, cpuErr, busReq;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busData;
  logic [BEW-1:0] busBe;
  logic busReady = 1'b1;
  logic ctlWe = 1'b0;
  logic [2:0] ctlWdata = '0;
  logic [2:0] cfgOut;

  int checks = 0;
  int failures = 0;
  logic [EW-1:0] expQ[$];

  always #4 clk = ~clk;

  storeRouter #(.AW(AW), .DW(DW), .DEPTH(4)) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuBe(cpuBe), .cpuInhibit(cpuInhibit), .cpuPrecise(cpuPrecise),
    .cpuRegionHit(cpuRegionHit), .cpuReady(cpuReady), .cpuErr(cpuErr),
    .busReq(busReq), .busAddr(busAddr), .busData(busData), .busBe(busBe),
    .busReady(busReady), .ctlWe(ctlWe), .ctlWdata(ctlWdata), .cfgOut(cfgOut)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every bus handshake pops the oldest expected write.
  always @(negedge clk) begin
    if (rstN && busReq && busReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 R8 unexpected bus write", longint'(busAddr), 0);
      end else begin
        logic [EW-1:0] e;
        e = expQ.pop_front();
        check({busAddr, busData, busBe} == e, "R6 R8 bus order/payload",
              longint'(busAddr), longint'(e[EW-1 -: AW]));
      end
    end
  end

  task automatic setCfg(input logic [2:0] v);
    @(posedge clk); #1;
    ctlWe = 1'b1; ctlWdata = v;
    @(posedge clk); #1;
    ctlWe = 1'b0;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic inh, input logic prec, input logic hit,
                         input bit expErr, input string tag, output int waited);
    @(posedge clk); #1;
    cpuReq = 1'b1; cpuAddr = a; cpuData = d; cpuBe = a[3:0];
    cpuInhibit = inh; cpuPrecise = prec; cpuRegionHit = hit;
    if (!expErr) expQ.push_back({a, d, a[3:0]});
    waited = 0;
    @(negedge clk);
    while (!cpuReady) begin
      waited++;
      @(negedge clk);
    end
    check(cpuErr == expErr, tag, cpuErr, expErr);
    @(posedge clk); #1;
    cpuReq = 1'b0;
  endtask

  task automatic releaseBusAfter(input int n);
    fork
      begin
        repeat (n) @(posedge clk);
        #1 busReady = 1'b1;
      end
    join_none
  endtask

  task automatic waitDrain();
    int guard;
    guard = 0;
    while ((expQ.size() != 0 || busReq) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    finishRun();
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(cfgOut == 3'b000, "R1 reset control word", cfgOut, 0);
    check(busReq == 1'b0, "R1 reset busReq", busReq, 0);
    check(cpuErr == 1'b0, "R1 reset cpuErr", cpuErr, 0);

    // After reset: no protection, buffer off -> direct, not faulted (R1, R5)
    busReady = 1'b0;
    releaseBusAfter(4);
    doWrite(32'h1000, 32'hA0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 no fault after reset", w);
    check(w >= 3, "R5 direct write waits for bus", w, 3);
    waitDrain();

    // Enable buffer; bufferable writes accepted at once (R3)
    setCfg(3'b101);
    @(negedge clk);
    check(cfgOut == 3'b101, "R1 control word load", cfgOut, 3'b101);
    busReady = 1'b0;
    for (int i = 0; i < 5; i++) begin
      doWrite(32'h2000 + i*4, 32'hB0 + i, i[0], 1'b0, 1'b1, 1'b0, "R3 buffered accept", w);
      check(w == 0, "R3 buffered write no wait", w, 0);
    end
    // R7: bus stalled with one on bus + 4 queued -> next stalls
    releaseBusAfter(6);
    doWrite(32'h2100, 32'hBF, 1'b0, 1'b0, 1'b1, 1'b0, "R7 full accept", w);
    check(w >= 5, "R7 full buffer holds ready low", w, 5);
    waitDrain();
    check(expQ.size() == 0, "R8 buffer drained", expQ.size(), 0);

    // R4/R6: precise inhibited direct behind queued writes
    busReady = 1'b0;
    doWrite(32'h3000, 32'hC0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 queue one", w);
    doWrite(32'h3004, 32'hC1, 1'b1, 1'b0, 1'b1, 1'b0, "R3 queue two", w);
    releaseBusAfter(5);
    doWrite(32'h3008, 32'hC2, 1'b1, 1'b1, 1'b1, 1'b0, "R4 precise direct", w);
    check(w >= 5, "R6 direct waits for drain", w, 5);
    waitDrain();

    // R4 with idle bus: still waits for its own handshake
    busReady = 1'b0;
    releaseBusAfter(3);
    doWrite(32'h3100, 32'hC3, 1'b1, 1'b1, 1'b1, 1'b0, "R4 precise bypass", w);
    check(w >= 2, "R4 ready only at handshake", w, 2);
    waitDrain();

    // R2: default write-protect
    setCfg(3'b011);
    doWrite(32'h4000, 32'hD0, 1'b0, 1'b0, 1'b0, 1'b1, "R2 fault on miss", w);
    check(w == 0, "R2 fault answered at once", w, 0);
    repeat (4) @(negedge clk);
    check(busReq == 1'b0, "R2 no bus cycle after fault", busReq, 0);
    doWrite(32'h4004, 32'hD1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 region hit not faulted", w);
    waitDrain();

    // R9: disable buffer with entries queued
    setCfg(3'b001);
    busReady = 1'b0;
    doWrite(32'h5000, 32'hE0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 queue a", w);
    doWrite(32'h5004, 32'hE1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 queue b", w);
    doWrite(32'h5008, 32'hE2, 1'b1, 1'b0, 1'b1, 1'b0, "R9 queue c", w);
    setCfg(3'b000);
    releaseBusAfter(4);
    doWrite(32'h500C, 32'hE3, 1'b0, 1'b0, 1'b1, 1'b0, "R9 write after disable", w);
    check(w >= 4, "R9 new write waits behind queued", w, 4);
    waitDrain();
    check(expQ.size() == 0, "R9 queued entries all reached bus", expQ.size(), 0);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule